// File: doc/BRIEF.md
# PCIe Outbound Window Decoder

This block is the address-translation register bank of a PCIe root-complex bridge. It sits on a 32-bit register bus and answers only inside its own 32-word block, placed by the `INST_BASE` parameter. Two copies of the bridge use bases 0x100 and 0x120.

The bank holds six address windows. Each window has a 64-bit base and a mask. The windows are a configuration-space window, a message window, three outbound memory windows and an internal-register window.

A lookup port takes a 64-bit address. One cycle later it reports whether a window claims the address, which window it is, the offset of the address inside that window, and the size of the window.

Bit 0 of every mask register enables its window. The window size is the two's complement of the mask with bit 0 cleared. The configuration, message and register windows have only a 32-bit mask, so the upper 32 mask bits of those windows act as all ones. The register window also treats one mask code as a 4 KiB window.

Top module: `pcieOutWinDec`

## Requirements
- R1: A window base is 64 bits, written as a low word and a high word. Writing either word leaves the other word unchanged. Outbound masks are split into low and high words in the same way.
- R2: Reset clears every base, mask and the scratch word, so every window is disabled. Every offset of the block then reads as zero, and no lookup hits.
- R3: An address hits window w when bit 0 of w's low mask is 1 and ((address XOR base) AND effective mask) is zero. The effective mask is the mask with bit 0 cleared. With bit 0 at 0 the window never hits.
- R4: The configuration, message and register windows have a single 32-bit mask; their effective mask carries ones in bits 63..32. The outbound windows use their full stored 64-bit mask.
- R5: On a hit, `lkOffset` = address AND NOT(effective mask), and `lkSize` = NOT(effective mask) + 1, both 64-bit.
- R6: A register-window mask of 0x0000_7001 is an enabled 4 KiB window: effective mask 0xFFFF_FFFF_FFFF_F000, size 0x1000. The register reads back as 0x7001.
- R7: When several windows hit, the lowest index wins. The indices, reported on `lkWin`, are: configuration = 0, message = 1, outbound 1..3 = 2..4, register window = 5.
- R8: Register-bus accesses whose address bits [9:5] differ from `INST_BASE[9:5]` are ignored: they write nothing and return no acknowledge.
- R9: A read inside the block raises `regRack` and presents `regRdata` in the cycle after `regRd`. Word offsets inside the block, relative to `INST_BASE`, are:
  - outbound n (n = 0..2): 4n = base low, 4n+1 = base high, 4n+2 = mask low, 4n+3 = mask high;
  - configuration window: 12 = base low, 13 = base high, 14 = mask;
  - message window: 16 = base low, 17 = base high, 18 = mask;
  - register window: 20 = base low, 21 = base high, 22 = mask;
  - scratch word: 24.

  All other offsets read as zero and ignore writes.
- R10: The scratch word at offset 24 holds any 32-bit value written to it and has no effect on lookups.
- R11: `lkDone` is high exactly in the cycle after `lkValid`. `lkHit` is low whenever `lkDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with regRack |
| regRack | output | 1 | Read acknowledge, one cycle after regRd |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 64 | Address to decode |
| lkDone | output | 1 | Lookup result valid |
| lkHit | output | 1 | Some window claims the address |
| lkWin | output | 3 | Index of the winning window |
| lkOffset | output | 64 | Offset inside the winning window |
| lkSize | output | 64 | Size of the winning window |

## Verification
A register write takes effect at the clock edge that samples it. Read data and `regRack` appear one edge after `regRd`, and lookup results appear one edge after `lkValid`.

The bench drives every strobe for a single cycle at a falling edge. It samples at the next falling edge, which falls exactly within the result cycle. For R11 it also checks that `lkDone` has dropped one cycle later.

Expected lookup results come from a bench-side copy of the written register values. The bench applies the hit rule, the priority order and the size formula from the requirements to that copy, over a sweep of addresses around every window edge.

// File: rtl/pcieWinPkg.sv
package pcieWinPkg;

  // register field selected by the control decoder
  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_BASE_LO,
    FLD_BASE_HI,
    FLD_MASK_LO,
    FLD_MASK_HI,
    FLD_SCRATCH
  } fld_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wr;
    logic       rd;
    fld_e       fld;
    logic [2:0] win;
  } regStb_t;

  localparam logic [31:0] REG_4K_CODE = 32'h0000_7001;
  localparam logic [63:0] REG_4K_MASK = 64'hFFFF_FFFF_FFFF_F000;

endpackage

// File: rtl/pcieWinCtrl.sv
module pcieWinCtrl
  import pcieWinPkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] INST_BASE = 'h100,
  parameter int              NUM_OB    = 3
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  output regStb_t           stb,
  output logic              ownSel
);
  localparam int OFS_W = 5;
  localparam logic [2:0] G_CFG = 3'(NUM_OB);
  localparam logic [2:0] G_MSG = 3'(NUM_OB + 1);
  localparam logic [2:0] G_REG = 3'(NUM_OB + 2);
  localparam logic [2:0] G_SCR = 3'(NUM_OB + 3);
  localparam logic [2:0] W_REG = 3'(NUM_OB + 2);

  logic [2:0] grp;
  logic [1:0] sub;
  fld_e       fld;
  logic [2:0] win;

  always_comb begin
    grp = regAddr[OFS_W-1:2];
    sub = regAddr[1:0];
    fld = FLD_NONE;
    win = '0;
    if (grp < G_CFG) begin
      win = grp + 3'd2;
      case (sub)
        2'd0:    fld = FLD_BASE_LO;
        2'd1:    fld = FLD_BASE_HI;
        2'd2:    fld = FLD_MASK_LO;
        default: fld = FLD_MASK_HI;
      endcase
    end else if (grp == G_SCR) begin
      if (sub == 2'd0) fld = FLD_SCRATCH;
    end else if (sub != 2'd3) begin
      if (grp == G_CFG)      win = 3'd0;
      else if (grp == G_MSG) win = 3'd1;
      else                   win = W_REG;
      if (grp == G_CFG || grp == G_MSG || grp == G_REG) begin
        case (sub)
          2'd0:    fld = FLD_BASE_LO;
          2'd1:    fld = FLD_BASE_HI;
          default: fld = FLD_MASK_LO;
        endcase
      end
    end
  end

  assign ownSel  = (regAddr[ADDR_W-1:OFS_W] == INST_BASE[ADDR_W-1:OFS_W]);
  assign stb.wr  = regWr & ownSel;
  assign stb.rd  = regRd & ownSel;
  assign stb.fld = fld;
  assign stb.win = win;

endmodule

// File: rtl/pcieWinPath.sv
module pcieWinPath
  import pcieWinPkg::*;
#(
  parameter int NUM_OB  = 3,
  parameter int NUM_WIN = NUM_OB + 3
) (
  input  logic        clk,
  input  logic        rst,
  input  regStb_t     stb,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        regRack,
  input  logic        lkValid,
  input  logic [63:0] lkAddr,
  output logic        lkDone,
  output logic        lkHit,
  output logic [2:0]  lkWin,
  output logic [63:0] lkOffset,
  output logic [63:0] lkSize
);
  localparam int REG_IDX = NUM_OB + 2;

  logic [63:0] baseW   [NUM_WIN];
  logic [31:0] mLoW    [NUM_WIN];
  logic [31:0] mHiW    [NUM_WIN];
  logic [63:0] effMask [NUM_WIN];
  logic [NUM_WIN-1:0] hitV;
  logic [31:0] scratchR;

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    localparam bit IS_OB  = (i >= 2) && (i < 2 + NUM_OB);
    localparam bit IS_REG = (i == REG_IDX);
    logic [63:0] baseR;
    logic [31:0] mLoR;
    logic        wrMe;

    assign wrMe = stb.wr && (stb.win == 3'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        baseR <= '0;
        mLoR  <= '0;
      end else if (wrMe) begin
        case (stb.fld)
          FLD_BASE_LO: baseR[31:0]  <= regWdata;
          FLD_BASE_HI: baseR[63:32] <= regWdata;
          FLD_MASK_LO: mLoR         <= regWdata;
          default: ;
        endcase
      end
    end

    if (IS_OB) begin : gHi
      logic [31:0] mHiR;
      always_ff @(posedge clk) begin
        if (rst) mHiR <= '0;
        else if (wrMe && stb.fld == FLD_MASK_HI) mHiR <= regWdata;
      end
      assign mHiW[i] = mHiR;
    end else begin : gNoHi
      assign mHiW[i] = '1;
    end

    if (IS_REG) begin : gReg
      assign effMask[i] = (mLoR == REG_4K_CODE) ? REG_4K_MASK
                                                : {mHiW[i], mLoR[31:1], 1'b0};
    end else begin : gPlain
      assign effMask[i] = {mHiW[i], mLoR[31:1], 1'b0};
    end

    assign baseW[i] = baseR;
    assign mLoW[i]  = mLoR;
    assign hitV[i]  = mLoR[0] && (((lkAddr ^ baseR) & effMask[i]) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) scratchR <= '0;
    else if (stb.wr && stb.fld == FLD_SCRATCH) scratchR <= regWdata;
  end

  // read mux
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (stb.fld == FLD_SCRATCH) rdMux = scratchR;
    else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (stb.win == 3'(i)) begin
          case (stb.fld)
            FLD_BASE_LO: rdMux = baseW[i][31:0];
            FLD_BASE_HI: rdMux = baseW[i][63:32];
            FLD_MASK_LO: rdMux = mLoW[i];
            FLD_MASK_HI: rdMux = mHiW[i];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRack  <= 1'b0;
      regRdata <= '0;
    end else begin
      regRack  <= stb.rd;
      regRdata <= stb.rd ? rdMux : '0;
    end
  end

  // priority pick: lowest index wins
  logic        anyHit;
  logic [2:0]  pick;
  logic [63:0] selMask;
  always_comb begin
    anyHit  = 1'b0;
    pick    = '0;
    selMask = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitV[i]) begin
        anyHit  = 1'b1;
        pick    = 3'(i);
        selMask = effMask[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lkDone   <= 1'b0;
      lkHit    <= 1'b0;
      lkWin    <= '0;
      lkOffset <= '0;
      lkSize   <= '0;
    end else begin
      lkDone <= lkValid;
      lkHit  <= lkValid & anyHit;
      if (lkValid) begin
        lkWin    <= anyHit ? pick : '0;
        lkOffset <= anyHit ? (lkAddr & ~selMask) : '0;
        lkSize   <= anyHit ? (~selMask + 64'd1) : '0;
      end
    end
  end

  assert_rack_R9: assert property (@(posedge clk) disable iff (rst)
    stb.rd |=> regRack);
  assert_done_R11: assert property (@(posedge clk) disable iff (rst)
    lkValid |=> lkDone);
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !lkValid |=> (!lkDone && !lkHit));
  assert_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lkHit && !regRack));

endmodule

// File: rtl/pcieOutWinDec.sv
module pcieOutWinDec
  import pcieWinPkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] INST_BASE = 'h100,
  parameter int                NUM_OB    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regRack,
  input  logic              lkValid,
  input  logic [63:0]       lkAddr,
  output logic              lkDone,
  output logic              lkHit,
  output logic [2:0]        lkWin,
  output logic [63:0]       lkOffset,
  output logic [63:0]       lkSize
);
  localparam int NUM_WIN = NUM_OB + 3;

  regStb_t stb;
  logic    ownSel;

  pcieWinCtrl #(.ADDR_W(ADDR_W), .INST_BASE(INST_BASE), .NUM_OB(NUM_OB)) i_ctrl (
    .regWr  (regWr),
    .regRd  (regRd),
    .regAddr(regAddr),
    .stb    (stb),
    .ownSel (ownSel)
  );

  pcieWinPath #(.NUM_OB(NUM_OB), .NUM_WIN(NUM_WIN)) i_path (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .regRack (regRack),
    .lkValid (lkValid),
    .lkAddr  (lkAddr),
    .lkDone  (lkDone),
    .lkHit   (lkHit),
    .lkWin   (lkWin),
    .lkOffset(lkOffset),
    .lkSize  (lkSize)
  );

  assert_foreign_R8: assert property (@(posedge clk) disable iff (rst)
    (regRd && !ownSel) |=> !regRack);

endmodule

// File: tb/test_pcieOutWinDec.sv
module test_pcieOutWinDec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRack;
  logic        lkValid = 1'b0;
  logic [63:0] lkAddr = '0;
  logic        lkDone, lkHit;
  logic [2:0]  lkWin;
  logic [63:0] lkOffset, lkSize;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  logic [63:0] sBase [6];
  logic [31:0] sLo [6];
  logic [31:0] sHi [6];

  always #10 clk = ~clk;

  pcieOutWinDec i_pcieOutWinDec (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int ofsOf(int w, int f);
    if (w >= 2 && w <= 4) return 4 * (w - 2) + f;
    if (w == 0) return 12 + f;
    if (w == 1) return 16 + f;
    return 20 + f;
  endfunction

  function automatic logic [63:0] effM(int w);
    if (w == 5 && sLo[5] == 32'h7001) return 64'hFFFF_FFFF_FFFF_F000;
    return {sHi[w], sLo[w][31:1], 1'b0};
  endfunction

  task automatic busWr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input logic [9:0] a, input bit expAck, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    chk(regRack == expAck, {tag, " ack"}, 64'(regRack), 64'(expAck));
    if (expAck) chk(regRdata == exp, {tag, " data"}, 64'(regRdata), 64'(exp));
  endtask

  task automatic winWr(input int w, input int f, input logic [31:0] d);
    busWr(10'(10'h100 + ofsOf(w, f)), d);
    case (f)
      0: sBase[w][31:0]  = d;
      1: sBase[w][63:32] = d;
      2: sLo[w] = d;
      default: sHi[w] = d;
    endcase
  endtask

  task automatic lkChk(input logic [63:0] a, input string tag);
    bit eh; int ew; logic [63:0] em, m;
    eh = 0; ew = 0; em = '0;
    for (int w = 5; w >= 0; w--) begin
      m = effM(w);
      if (sLo[w][0] && (((a ^ sBase[w]) & m) == '0)) begin
        eh = 1; ew = w; em = m;
      end
    end
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a;
    @(negedge clk);
    lkValid = 1'b0;
    chk(lkDone == 1'b1, {tag, " R11 done"}, 64'(lkDone), 64'd1);
    chk(lkHit == eh, {tag, " R3 hit"}, 64'(lkHit), 64'(eh));
    if (eh) begin
      chk(lkWin == 3'(ew), {tag, " R7 win"}, 64'(lkWin), 64'(ew));
      chk(lkOffset == (a & ~em), {tag, " R5 offset"}, lkOffset, a & ~em);
      chk(lkSize == (~em + 64'd1), {tag, " R5 size"}, lkSize, ~em + 64'd1);
    end
  endtask

  task automatic sweep(input string tag);
    logic [63:0] offs [13];
    offs = '{64'h0, 64'h1, 64'hFFF, 64'h1000, 64'hFFFF, 64'h1_0000, 64'h0FFF_FFFF,
             64'h1000_0000, 64'h3FFF_FFFF, 64'h4000_0000, 64'hF_FFFF_FFFF,
             64'h10_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
    for (int w = 0; w < 6; w++) begin
      for (int k = 0; k < 13; k++) lkChk(sBase[w] + offs[k], tag);
    end
  endtask

  initial begin
    for (int w = 0; w < 6; w++) begin
      sBase[w] = '0; sLo[w] = '0;
      sHi[w] = (w >= 2 && w <= 4) ? 32'h0 : 32'hFFFF_FFFF;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(regRack == 1'b0 && lkHit == 1'b0 && lkDone == 1'b0, "R2 outputs after reset",
        64'({regRack, lkHit, lkDone}), 64'd0);
    // R2 / R9: every offset reads zero after reset
    for (int o = 0; o < 32; o++) rdChk(10'(10'h100 + o), 1'b1, 32'h0, "R2 reset readback");
    lkChk(64'h0, "R2 no hit after reset");
    lkChk(64'h1234_5678_9ABC_DEF0, "R2 no hit after reset");

    // R10 scratch
    busWr(10'h118, 32'hA5A5_5A5A);
    rdChk(10'h118, 1'b1, 32'hA5A5_5A5A, "R10 scratch");
    lkChk(64'h0, "R10 scratch no effect");
    // R9 undefined offsets ignore writes
    busWr(10'h10F, 32'hDEAD_BEEF);
    rdChk(10'h10F, 1'b1, 32'h0, "R9 undefined offset");
    busWr(10'h11F, 32'hDEAD_BEEF);
    rdChk(10'h11F, 1'b1, 32'h0, "R9 undefined offset");

    // R1 half writes keep the other half
    for (int w = 0; w < 6; w++) begin
      winWr(w, 0, 32'h1111_0000 + 32'(w));
      rdChk(10'(10'h100 + ofsOf(w, 1)), 1'b1, 32'h0, "R1 high untouched");
      winWr(w, 1, 32'h2222_0000 + 32'(w));
      rdChk(10'(10'h100 + ofsOf(w, 0)), 1'b1, 32'h1111_0000 + 32'(w), "R1 low kept");
      rdChk(10'(10'h100 + ofsOf(w, 1)), 1'b1, 32'h2222_0000 + 32'(w), "R1 high written");
    end
    for (int w = 2; w < 5; w++) begin
      winWr(w, 3, 32'h3333_0000 + 32'(w));
      rdChk(10'(10'h100 + ofsOf(w, 2)), 1'b1, 32'h0, "R1 mask low untouched");
      rdChk(10'(10'h100 + ofsOf(w, 3)), 1'b1, 32'h3333_0000 + 32'(w), "R1 mask high");
    end

    // R8 foreign instance block ignored
    busWr(10'h138, 32'h0BAD_0BAD);
    busWr(10'h120, 32'h0BAD_0BAD);
    rdChk(10'h138, 1'b0, 32'h0, "R8 foreign read no ack");
    rdChk(10'h118, 1'b1, 32'hA5A5_5A5A, "R8 own scratch unchanged");
    rdChk(10'h100, 1'b1, 32'h1111_0002, "R8 own base unchanged");

    // R3 R4 R5 main configuration
    winWr(0, 0, 32'h4000_0000); winWr(0, 1, 32'h0); winWr(0, 2, 32'hF000_0001);
    winWr(1, 0, 32'h5000_0000); winWr(1, 1, 32'h0); winWr(1, 2, 32'hFFFF_0001);
    winWr(2, 0, 32'h0);         winWr(2, 1, 32'h8); winWr(2, 2, 32'hC000_0001); winWr(2, 3, 32'hFFFF_FFFF);
    winWr(3, 0, 32'h0);         winWr(3, 1, 32'h10); winWr(3, 2, 32'h0000_0001); winWr(3, 3, 32'hFFFF_FFF0);
    winWr(4, 0, 32'h0);         winWr(4, 1, 32'h20); winWr(4, 2, 32'hFFFF_0000); winWr(4, 3, 32'hFFFF_FFFF);
    winWr(5, 0, 32'h6000_0000); winWr(5, 1, 32'h0); winWr(5, 2, 32'h0000_7001);
    rdChk(10'h116, 1'b1, 32'h0000_7001, "R6 mask readback");
    sweep("R4 sweep A");
    lkChk(64'h0000_0020_0000_0010, "R3 disabled outbound");
    winWr(4, 2, 32'hFFFF_0001);
    lkChk(64'h0000_0020_0000_0010, "R3 enabled outbound");
    lkChk(64'h0000_0020_0001_0000, "R3 past outbound end");
    lkChk(64'h0000_0001_4000_0000, "R4 upper bits on 32-bit window");

    // R6 register window 4 KiB code
    lkChk(64'h6000_0FFF, "R6 last byte");
    lkChk(64'h6000_1000, "R6 first outside");
    winWr(5, 2, 32'h0000_7000);
    lkChk(64'h6000_0000, "R6 disabled");
    winWr(5, 2, 32'hFFFF_E001);
    lkChk(64'h6000_1FFF, "R6 plain mask");

    // R7 priority over overlapping windows
    winWr(1, 0, 32'h4000_0000);
    winWr(2, 0, 32'h4000_0000); winWr(2, 1, 32'h0);
    winWr(5, 0, 32'h4000_0000); winWr(5, 2, 32'h0000_7001);
    lkChk(64'h4000_0010, "R7 cfg wins");
    winWr(0, 2, 32'hF000_0000);
    lkChk(64'h4000_0010, "R7 msg wins");
    winWr(1, 2, 32'hFFFF_0000);
    lkChk(64'h4000_0010, "R7 outbound wins");
    winWr(2, 2, 32'hC000_0000);
    lkChk(64'h4000_0010, "R7 register window wins");
    sweep("R7 sweep B");

    // R11 done drops after one cycle
    lkChk(64'h4000_0000, "R11 pulse");
    @(negedge clk);
    chk(lkDone == 1'b0 && lkHit == 1'b0, "R11 done low when idle", 64'({lkDone, lkHit}), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule